// File: doc/BRIEF.md
# Condition Flag Register and Next-PC Sequencer

This block keeps the program counter and a four-bit condition register (negative, zero, overflow, carry) for a simple 32-bit processor with byte addressing and one-word instructions. When the update strobe is high it records the flags of an ALU result. The result's sign gives the negative flag and an all-zero result gives the zero flag. The carry-out and overflow indications are copied as they are.

On every step strobe the block picks the next PC. That is either the sequential address, four bytes on, or the branch target that comes with a branch request. A branch is taken only when the selected condition holds on the flags already stored. The counter register that a loop decrements is never examined. A greater-than-zero branch placed after a decrement is therefore resolved from the flags that the decrement left behind.

Top module: `cc_branch_seq`

## Requirements
- R1: While reset is low, and just after reset is released, the PC equals the START_ADDR parameter (default 0x100) and all four flags are 0.
- R2: A step with no branch request sets the PC to the old PC plus 4.
- R3: When step is low the PC keeps its value, even if a branch request and target are present.
- R4: When the flag update strobe is high, the negative flag takes bit 31 of the result and the zero flag is set exactly when all 32 result bits are 0.
- R5: When the flag update strobe is high, the overflow flag takes the value of the ALU overflow input and the carry flag takes the value of the carry-out input.
- R6: When the update strobe is low the four flags keep their values, including on branch steps.
- R7: A step with a branch request whose condition holds loads the target into the PC. Otherwise the PC is the old PC plus 4. Condition codes: 0 always, 1 zero set, 2 zero clear, 4 negative set, 5 carry set, 6 and 7 never.
- R8: Condition code 3 (greater than zero) is taken when Z=0 and N equals V. It falls through when Z=1 or N differs from V.
- R9: A branch decision uses the flags stored before the cycle. A flag update in the same cycle affects only later branches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| step | input | 1 | One instruction completes this cycle |
| brReq | input | 1 | The completing instruction is a branch |
| condSel | input | 3 | Branch condition code |
| brTarget | input | 32 | Branch target byte address |
| flagUpd | input | 1 | Record flags from the ALU inputs |
| aluResult | input | 32 | ALU result |
| aluCarry | input | 1 | ALU carry-out |
| aluOvf | input | 1 | ALU signed overflow |
| pc | output | 32 | Program counter |
| flagN | output | 1 | Stored negative flag |
| flagZ | output | 1 | Stored zero flag |
| flagV | output | 1 | Stored overflow flag |
| flagC | output | 1 | Stored carry flag |

## Verification
A flag update and a conditional branch step can occur in the same cycle. The bench drives a zero-result update together with a not-equal branch while the stored zero flag is clear. The branch must be taken on the old flags, and the new zero flag must be visible on the following edge. A second not-equal branch one cycle later must then fall through, which shows that the new flag is used from that cycle onwards.

// File: rtl/ccseq_pkg.sv
package ccseq_pkg;

  typedef enum logic [2:0] {
    COND_ALWAYS = 3'd0,
    COND_EQ     = 3'd1,
    COND_NE     = 3'd2,
    COND_GT     = 3'd3,
    COND_NEG    = 3'd4,
    COND_CARRY  = 3'd5,
    COND_NONE6  = 3'd6,
    COND_NONE7  = 3'd7
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  typedef struct packed {
    logic advance;
    logic loadTarget;
    logic writeFlags;
  } ctrl_t;

endpackage

// File: rtl/ccseq_ctrl.sv
module ccseq_ctrl
  import ccseq_pkg::*;
(
  input  logic        step,
  input  logic        brReq,
  input  logic [2:0]  condSel,
  input  logic        flagUpd,
  input  flags_t      curFlags,
  output ctrl_t       ctrl
);

  logic condMet;

  always_comb begin
    unique case (cond_e'(condSel))
      COND_ALWAYS: condMet = 1'b1;
      COND_EQ:     condMet = curFlags.z;
      COND_NE:     condMet = !curFlags.z;
      COND_GT:     condMet = !curFlags.z && (curFlags.n == curFlags.v);
      COND_NEG:    condMet = curFlags.n;
      COND_CARRY:  condMet = curFlags.c;
      default:     condMet = 1'b0;
    endcase
  end

  always_comb begin
    ctrl.advance    = step;
    ctrl.loadTarget = step && brReq && condMet;
    ctrl.writeFlags = flagUpd;
  end

endmodule

// File: rtl/ccseq_dpath.sv
module ccseq_dpath
  import ccseq_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          DATA_W     = 32,
  parameter int          INSN_BYTES = 4,
  parameter logic [31:0] START_ADDR = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [ADDR_W-1:0] brTarget,
  input  logic [DATA_W-1:0] aluResult,
  input  logic              aluCarry,
  input  logic              aluOvf,
  output logic [ADDR_W-1:0] pcReg,
  output flags_t            flagReg
);

  localparam logic [ADDR_W-1:0] PC_INC   = ADDR_W'(INSN_BYTES);
  localparam logic [ADDR_W-1:0] PC_RESET = ADDR_W'(START_ADDR);

  logic [ADDR_W-1:0] seqAddr;
  flags_t            newFlags;

  assign seqAddr = pcReg + PC_INC;

  always_comb begin
    newFlags.n = aluResult[DATA_W-1];
    newFlags.z = (aluResult == '0);
    newFlags.v = aluOvf;
    newFlags.c = aluCarry;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcReg <= PC_RESET;
    end else if (ctrl.advance) begin
      pcReg <= ctrl.loadTarget ? brTarget : seqAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagReg <= '0;
    end else if (ctrl.writeFlags) begin
      flagReg <= newFlags;
    end
  end

endmodule

// File: rtl/cc_branch_seq.sv
module cc_branch_seq
  import ccseq_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          DATA_W     = 32,
  parameter int          INSN_BYTES = 4,
  parameter logic [31:0] START_ADDR = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              step,
  input  logic              brReq,
  input  logic [2:0]        condSel,
  input  logic [ADDR_W-1:0] brTarget,
  input  logic              flagUpd,
  input  logic [DATA_W-1:0] aluResult,
  input  logic              aluCarry,
  input  logic              aluOvf,
  output logic [ADDR_W-1:0] pc,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagV,
  output logic              flagC
);

  ctrl_t  ctrl;
  flags_t flagReg;

  ccseq_ctrl ctrl_i (
    .step     (step),
    .brReq    (brReq),
    .condSel  (condSel),
    .flagUpd  (flagUpd),
    .curFlags (flagReg),
    .ctrl     (ctrl)
  );

  ccseq_dpath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .INSN_BYTES (INSN_BYTES),
    .START_ADDR (START_ADDR)
  ) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .brTarget  (brTarget),
    .aluResult (aluResult),
    .aluCarry  (aluCarry),
    .aluOvf    (aluOvf),
    .pcReg     (pc),
    .flagReg   (flagReg)
  );

  assign flagN = flagReg.n;
  assign flagZ = flagReg.z;
  assign flagV = flagReg.v;
  assign flagC = flagReg.c;

endmodule

// File: rtl/cc_branch_seq_chk.sv
module cc_branch_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              step,
  input logic              brReq,
  input logic [2:0]        condSel,
  input logic [ADDR_W-1:0] brTarget,
  input logic              flagUpd,
  input logic [DATA_W-1:0] aluResult,
  input logic              aluCarry,
  input logic              aluOvf,
  input logic [ADDR_W-1:0] pc,
  input logic              flagN,
  input logic              flagZ,
  input logic              flagV,
  input logic              flagC
);

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (step && !brReq) |=> (pc == $past(pc) + ADDR_W'(4))); // R2

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !step |=> $stable(pc)); // R3

  AST_NZ_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    flagUpd |=> (flagZ == ($past(aluResult) == '0)) && (flagN == $past(aluResult[DATA_W-1]))); // R4

  AST_VC_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    flagUpd |=> (flagV == $past(aluOvf)) && (flagC == $past(aluCarry))); // R5

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !flagUpd |=> $stable({flagN, flagZ, flagV, flagC})); // R6

  AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (step && brReq && condSel == 3'd0) |=> (pc == $past(brTarget))); // R7

  AST_GT_FALLS: assert property (@(posedge clk) disable iff (!rstN)
    (step && brReq && condSel == 3'd3 && flagZ) |=> (pc == $past(pc) + ADDR_W'(4))); // R8

  AST_OLD_FLAGS_USED: assert property (@(posedge clk) disable iff (!rstN)
    (step && brReq && condSel == 3'd2 && !flagZ && flagUpd) |=> (pc == $past(brTarget))); // R9

endmodule

bind cc_branch_seq cc_branch_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/cc_branch_seq_tb.sv
module cc_branch_seq_tb_top;

  typedef struct {
    logic [31:0] pc;
    logic [3:0]  fl;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN;
  logic        step, brReq, flagUpd, aluCarry, aluOvf;
  logic [2:0]  condSel;
  logic [31:0] brTarget, aluResult, pc;
  logic        flagN, flagZ, flagV, flagC;

  exp_t        expQ[$];
  int          total = 0;
  int          bad = 0;
  bit          finished = 0;

  logic [31:0] mPc;
  logic        mN, mZ, mV, mC;

  always #5 clk = ~clk;

  cc_branch_seq dut_i (
    .clk(clk), .rstN(rstN), .step(step), .brReq(brReq), .condSel(condSel),
    .brTarget(brTarget), .flagUpd(flagUpd), .aluResult(aluResult),
    .aluCarry(aluCarry), .aluOvf(aluOvf), .pc(pc),
    .flagN(flagN), .flagZ(flagZ), .flagV(flagV), .flagC(flagC)
  );

  function automatic logic condHolds(input logic [2:0] cs);
    case (cs)
      3'd0: return 1'b1;
      3'd1: return mZ;
      3'd2: return !mZ;
      3'd3: return !mZ && (mN == mV);
      3'd4: return mN;
      3'd5: return mC;
      default: return 1'b0;
    endcase
  endfunction

  task automatic doCycle(input logic st, input logic br, input logic [2:0] cs,
                         input logic [31:0] tgt, input logic upd,
                         input logic [31:0] res, input logic cy, input logic ov,
                         input string tag);
    exp_t e;
    @(negedge clk);
    step = st; brReq = br; condSel = cs; brTarget = tgt;
    flagUpd = upd; aluResult = res; aluCarry = cy; aluOvf = ov;
    if (st) mPc = (br && condHolds(cs)) ? tgt : mPc + 32'd4;
    if (upd) begin
      mN = res[31]; mZ = (res == 32'd0); mV = ov; mC = cy;
    end
    e.pc = mPc; e.fl = {mN, mZ, mV, mC}; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic goIdle();
    @(negedge clk);
    step = 0; brReq = 0; flagUpd = 0; condSel = 3'd0;
    brTarget = 32'hDEAD_BEE0; aluResult = 32'h1; aluCarry = 0; aluOvf = 0;
  endtask

  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      total++;
      if (pc !== e.pc || {flagN, flagZ, flagV, flagC} !== e.fl) begin
        bad++;
        $display("FAIL %s: pc=%h flags=%b expected pc=%h flags=%b",
                 e.tag, pc, {flagN, flagZ, flagV, flagC}, e.pc, e.fl);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: run incomplete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 0; step = 0; brReq = 0; flagUpd = 0; condSel = 3'd0;
    brTarget = 32'h0; aluResult = 32'h0; aluCarry = 0; aluOvf = 0;
    mPc = 32'h100; mN = 0; mZ = 0; mV = 0; mC = 0;
    repeat (3) @(negedge clk);
    total++;
    if (pc !== 32'h100 || {flagN, flagZ, flagV, flagC} !== 4'b0000) begin
      bad++;
      $display("FAIL R1: pc=%h flags=%b expected pc=00000100 flags=0000",
               pc, {flagN, flagZ, flagV, flagC});
    end
    rstN = 1;
    // R1 held after release
    doCycle(0, 0, 3'd0, 32'h0, 0, 32'h0, 0, 0, "R1");
    // R2 sequential steps
    doCycle(1, 0, 3'd0, 32'h0, 0, 32'h0, 0, 0, "R2");
    doCycle(1, 0, 3'd0, 32'h4444, 0, 32'h0, 0, 0, "R2");
    // R3 branch request without step is ignored
    doCycle(0, 1, 3'd0, 32'h0000_0800, 0, 32'h0, 0, 0, "R3");
    // R4 / R5 flag capture
    doCycle(0, 0, 3'd0, 32'h0, 1, 32'h8000_0000, 1, 0, "R4_R5");
    doCycle(0, 0, 3'd0, 32'h0, 1, 32'h0000_0000, 0, 1, "R4_R5");
    // R7 eq taken with flags held (R6)
    doCycle(1, 1, 3'd1, 32'h0000_0200, 0, 32'h7, 1, 1, "R7_R6");
    doCycle(1, 1, 3'd2, 32'h0000_0300, 0, 32'h0, 0, 0, "R7");
    doCycle(1, 1, 3'd0, 32'h0000_0400, 0, 32'h0, 0, 0, "R7");
    // R8 greater-than-zero cases
    doCycle(0, 0, 3'd0, 32'h0, 1, 32'h5, 0, 0, "R4");
    doCycle(1, 1, 3'd3, 32'h0000_0500, 0, 32'h0, 0, 0, "R8");
    doCycle(0, 0, 3'd0, 32'h0, 1, 32'hFFFF_FFFF, 0, 1, "R5");
    doCycle(1, 1, 3'd3, 32'h0000_0600, 0, 32'h0, 0, 0, "R8");
    doCycle(0, 0, 3'd0, 32'h0, 1, 32'hFFFF_FFFF, 1, 0, "R4");
    doCycle(1, 1, 3'd3, 32'h0000_0700, 0, 32'h0, 0, 0, "R8");
    // R8 countdown loop: decrement then branch on stored flags
    for (int k = 2; k >= 0; k--) begin
      doCycle(1, 0, 3'd0, 32'h0, 1, 32'(k), 0, 0, "R8");
      doCycle(1, 1, 3'd3, 32'h0000_0A00, 0, 32'h0, 0, 0, "R8");
    end
    // R7 negative, carry, never
    doCycle(0, 0, 3'd0, 32'h0, 1, 32'h8000_0001, 1, 0, "R4");
    doCycle(1, 1, 3'd4, 32'h0000_0B00, 0, 32'h0, 0, 0, "R7");
    doCycle(1, 1, 3'd5, 32'h0000_0C00, 0, 32'h0, 0, 0, "R7");
    doCycle(1, 1, 3'd6, 32'h0000_0D00, 0, 32'h0, 0, 0, "R7");
    doCycle(1, 1, 3'd7, 32'h0000_0E00, 0, 32'h0, 0, 0, "R7");
    doCycle(0, 0, 3'd0, 32'h0, 1, 32'h1, 0, 0, "R4");
    doCycle(1, 1, 3'd5, 32'h0000_0F00, 0, 32'h0, 0, 0, "R7");
    doCycle(1, 1, 3'd4, 32'h0000_0F40, 0, 32'h0, 0, 0, "R7");
    // R9 update and branch in the same cycle
    doCycle(1, 1, 3'd2, 32'h0000_1000, 1, 32'h0, 0, 0, "R9");
    doCycle(1, 1, 3'd2, 32'h0000_2000, 0, 32'h0, 0, 0, "R9");
    doCycle(1, 1, 3'd1, 32'h0000_3000, 1, 32'h9, 1, 0, "R9");
    doCycle(1, 1, 3'd1, 32'h0000_4000, 0, 32'h0, 0, 0, "R9");
    goIdle();
    while (expQ.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule